// File: doc/BRIEF.md
# Battery Pack Protection Control Register

This block holds the control settings of a battery-pack protection controller and drives the matching pins. The settings are a current-sense gain code, a charge FET enable, a discharge FET enable and four cell-balance enables. A host reaches the block through a parallel command channel with a valid/ready handshake. A write command loads a new control word. A read command returns an 8-bit status word built from internal detection flags, and that word comes back on a response channel that also has a valid/ready handshake.

When protection mode is active, the FET pins are frozen at the values they had when protection began. Writes are still accepted during that time. The first clock edge that sees protection mode released loads the most recent register contents onto the FET pins. The gain code and the balance pins always follow the register at once.

Back-pressure on the command channel comes only from the response channel. `cmd_ready` goes low while a response is waiting and `rsp_ready` is low. In that state the response stays valid and its data does not change.

Top module: `bpc_prot_ctrl`

## Requirements
- R1: `gain_sel` equals bits [1:0] of the control word. Code 00 selects x10, 01 selects x25, 10 selects x80 and 11 selects x160.
- R2: Bit 2 of the control word is the charge enable. When it is 1, `chg_fet_n` is low (FET on). When it is 0, `chg_fet_n` is high (FET off).
- R3: Bit 3 of the control word is the discharge enable. When it is 1, `dsg_fet_n` is low (FET on). When it is 0, `dsg_fet_n` is high (FET off).
- R4: Bits [7:4] of the control word drive `bal_en[3:0]` one to one. A value of 1 drives the pin high (on), and each bit is independent of the others.
- R5: At any clock edge where `prot_active` is high, `chg_fet_n` and `dsg_fet_n` do not change. At an edge where it is low, they take the register value that is in force after that edge, including a write accepted on that same edge.
- R6: Status word bits [7:3] read 0. Bit 2 is `chg_ctl_flag`, bit 1 is `uv_det`, and bit 0 is `vreg_unsettled` OR `oc_det`.
- R7: After reset, the control word is 0. Both FET pins are high, all balance pins are low, the gain code is 00 and `rsp_valid` is low.
- R8: A write is accepted at an edge where `cmd_valid`, `cmd_ready` and `cmd_write` are all high. The new gain and balance values appear right after that edge, whatever the state of `prot_active`.
- R9: A read is accepted at an edge where `cmd_valid` and `cmd_ready` are high and `cmd_write` is low. The flags are captured at that edge into `rsp_data` and `rsp_valid` rises. The response stays valid and stable until an edge where `rsp_ready` is high. `cmd_ready` equals NOT `rsp_valid` OR `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_write | input | 1 | 1 = write control word, 0 = read status |
| cmd_wdata | input | 8 | Control word for a write |
| rsp_valid | output | 1 | Status response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 8 | Status word |
| prot_active | input | 1 | Protection mode in force |
| chg_ctl_flag | input | 1 | Charge-control status flag |
| uv_det | input | 1 | Under-voltage detect flag |
| vreg_unsettled | input | 1 | Regulator not yet tuned |
| oc_det | input | 1 | Over-current protection flag |
| gain_sel | output | 2 | Current-sense gain code |
| chg_fet_n | output | 1 | Charge FET drive, low = on |
| dsg_fet_n | output | 1 | Discharge FET drive, low = on |
| bal_en | output | 4 | Cell-balance drives, high = on |

## Verification
The assertions assume that the inputs hold steady around each rising edge. They also assume that `rsp_ready` is meaningful only while a response is pending, and that the detection flags and `prot_active` are already synchronous to `clk`. The stimulus drives every input on the falling edge only, so each value is settled at the rising edge that samples it. Random `rsp_ready` patterns create stalls on purpose, and long `prot_active` bursts with writes inside them exercise the frozen-pin path and its release.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int GAIN_W = 2;
  localparam int BAL_N  = 4;
  localparam int CTRL_W = GAIN_W + 2 + BAL_N;
  localparam int STAT_W = 8;
  localparam int FLAG_N = 3;

  typedef struct packed {
    logic [BAL_N-1:0]  bal;
    logic              dsg;
    logic              chg;
    logic [GAIN_W-1:0] gain;
  } ctrl_t;
endpackage

// File: rtl/bpc_ctrl_reg.sv
module bpc_ctrl_reg
  import bpc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  ctrl_t wr_data,
  output ctrl_t ctrl_d,
  output ctrl_t ctrl_q
);
  always_comb ctrl_d = wr_en ? wr_data : ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  // R8: an accepted write lands in the register on that same edge
  p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_q == $past(wr_data));
endmodule

// File: rtl/bpc_fet_hold.sv
module bpc_fet_hold
  import bpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic prot_active,
  input  logic chg_next,
  input  logic dsg_next,
  output logic chg_fet_n,
  output logic dsg_fet_n
);
  logic chg_lat, dsg_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_lat <= 1'b0;
      dsg_lat <= 1'b0;
    end else if (!prot_active) begin
      chg_lat <= chg_next;
      dsg_lat <= dsg_next;
    end
  end

  assign chg_fet_n = ~chg_lat;
  assign dsg_fet_n = ~dsg_lat;

  p_fet_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prot_active |=> $stable(chg_fet_n) && $stable(dsg_fet_n));

  // R2 and R3: outside protection the pins track the enables, active low
  p_fet_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_active |=> chg_fet_n == !$past(chg_next));
  p_fet_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_active |=> dsg_fet_n == !$past(dsg_next));
endmodule

// File: rtl/bpc_status_pack.sv
module bpc_status_pack
  import bpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              rsp_ready,
  input  logic              chg_ctl_flag,
  input  logic              uv_det,
  input  logic              vreg_unsettled,
  input  logic              oc_det,
  output logic              rsp_valid,
  output logic [STAT_W-1:0] rsp_data
);
  logic [STAT_W-1:0] word;

  always_comb begin
    word[0] = vreg_unsettled | oc_det;
    word[1] = uv_det;
    word[2] = chg_ctl_flag;
  end

  for (genvar i = FLAG_N; i < STAT_W; i++) begin : g_pad
    assign word[i] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_data[STAT_W-1:FLAG_N] == '0);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  p_or_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rsp_data[0] == ($past(vreg_unsettled) || $past(oc_det)));
endmodule

// File: rtl/bpc_prot_ctrl.sv
module bpc_prot_ctrl
  import bpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [CTRL_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [STAT_W-1:0] rsp_data,
  input  logic              prot_active,
  input  logic              chg_ctl_flag,
  input  logic              uv_det,
  input  logic              vreg_unsettled,
  input  logic              oc_det,
  output logic [GAIN_W-1:0] gain_sel,
  output logic              chg_fet_n,
  output logic              dsg_fet_n,
  output logic [BAL_N-1:0]  bal_en
);
  logic  accept, wr_en, rd_en;
  ctrl_t ctrl_d, ctrl_q;

  assign cmd_ready = ~rsp_valid | rsp_ready;
  assign accept    = cmd_valid & cmd_ready;
  assign wr_en     = accept & cmd_write;
  assign rd_en     = accept & ~cmd_write;

  bpc_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (ctrl_t'(cmd_wdata)),
    .ctrl_d  (ctrl_d),
    .ctrl_q  (ctrl_q)
  );

  bpc_fet_hold u_fet (
    .clk         (clk),
    .rst_n       (rst_n),
    .prot_active (prot_active),
    .chg_next    (ctrl_d.chg),
    .dsg_next    (ctrl_d.dsg),
    .chg_fet_n   (chg_fet_n),
    .dsg_fet_n   (dsg_fet_n)
  );

  bpc_status_pack u_stat (
    .clk            (clk),
    .rst_n          (rst_n),
    .load           (rd_en),
    .rsp_ready      (rsp_ready),
    .chg_ctl_flag   (chg_ctl_flag),
    .uv_det         (uv_det),
    .vreg_unsettled (vreg_unsettled),
    .oc_det         (oc_det),
    .rsp_valid      (rsp_valid),
    .rsp_data       (rsp_data)
  );

  assign gain_sel = ctrl_q.gain;

  for (genvar b = 0; b < BAL_N; b++) begin : g_bal
    assign bal_en[b] = ctrl_q.bal[b];
  end

  p_bal_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> bal_en == $past(cmd_wdata[CTRL_W-1:GAIN_W+2]));

  p_gain_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> gain_sel == $past(cmd_wdata[GAIN_W-1:0]));

  p_read_rises_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid);
endmodule

// File: tb/bpc_prot_ctrl_tb.sv
module bpc_prot_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_write = 0, rsp_ready = 0, prot_active = 0;
  logic chg_ctl_flag = 0, uv_det = 0, vreg_unsettled = 0, oc_det = 0;
  logic [7:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, chg_fet_n, dsg_fet_n;
  logic [7:0] rsp_data;
  logic [1:0] gain_sel;
  logic [3:0] bal_en;

  int n_tests = 0, n_fail = 0;
  logic [7:0] m_ctrl = '0;
  logic m_chg = 0, m_dsg = 0, m_pend = 0;
  logic [7:0] m_rsp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bpc_prot_ctrl dut_i (.*);

  function automatic logic [7:0] stat_word(logic c, logic u, logic v, logic o);
    return {5'b0, c, u, v | o};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // apply inputs at negedge, check ready before edge, advance model, check after edge
  task automatic step(logic v, logic w, logic [7:0] d, logic rr, logic p,
                      logic [3:0] fl);
    logic acc;
    @(negedge clk);
    cmd_valid = v; cmd_write = w; cmd_wdata = d; rsp_ready = rr; prot_active = p;
    {chg_ctl_flag, uv_det, vreg_unsettled, oc_det} = fl;
    #1;
    chk("R9 cmd_ready", {7'b0, cmd_ready}, {7'b0, (!m_pend || rr)});
    acc = v && (!m_pend || rr);
    if (acc && w) m_ctrl = d;
    if (!p) begin m_chg = m_ctrl[2]; m_dsg = m_ctrl[3]; end
    if (acc && !w) begin m_pend = 1; m_rsp = stat_word(fl[3], fl[2], fl[1], fl[0]); end
    else if (rr) m_pend = 0;
    @(posedge clk); #1;
    chk("R1 R8 gain", {6'b0, gain_sel}, {6'b0, m_ctrl[1:0]});
    chk("R4 R8 balance", {4'b0, bal_en}, {4'b0, m_ctrl[7:4]});
    chk(p ? "R5 R2 chg pin held" : "R2 R5 chg pin", {7'b0, chg_fet_n}, {7'b0, !m_chg});
    chk(p ? "R5 R3 dsg pin held" : "R3 R5 dsg pin", {7'b0, dsg_fet_n}, {7'b0, !m_dsg});
    chk("R9 rsp_valid", {7'b0, rsp_valid}, {7'b0, m_pend});
    if (m_pend) chk("R6 R9 status", rsp_data, m_rsp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    #(CLK_PERIOD * 2 + 2);
    // R7: reset state
    chk("R7 chg pin", {7'b0, chg_fet_n}, 8'd1);
    chk("R7 dsg pin", {7'b0, dsg_fet_n}, 8'd1);
    chk("R7 balance", {4'b0, bal_en}, 8'd0);
    chk("R7 gain", {6'b0, gain_sel}, 8'd0);
    chk("R7 rsp_valid", {7'b0, rsp_valid}, 8'd0);
    rst_n = 1'b1;

    // directed: each gain code and each balance bit alone
    for (int g = 0; g < 4; g++) step(1, 1, 8'(g), 0, 0, 4'h0);
    for (int b = 0; b < 4; b++) step(1, 1, 8'(1 << (b + 4)), 0, 0, 4'h0);
    // both FETs on, then protection with writes inside
    step(1, 1, 8'h0C, 0, 0, 4'h0);
    step(1, 1, 8'h00, 0, 1, 4'h0);   // R5: write at entry edge stays off pins
    step(1, 1, 8'h54, 0, 1, 4'h0);   // R8: balance/gain follow during protection
    step(0, 0, 8'h00, 0, 1, 4'h0);
    step(0, 0, 8'h00, 0, 0, 4'h0);   // R5: release loads latest (chg on, dsg off)
    // R6: status OR bit from each source, padding zero
    step(1, 0, 8'h00, 0, 0, 4'b0010);
    step(0, 0, 8'h00, 0, 0, 4'h0);   // R9: held while rsp_ready low
    step(1, 1, 8'hFF, 1, 0, 4'h0);   // R9: accepted together with pop
    step(1, 0, 8'h00, 0, 0, 4'b0001);
    step(1, 1, 8'h33, 0, 0, 4'h0);   // R9: blocked, must not write
    step(1, 0, 8'h00, 1, 0, 4'b1100);
    step(0, 0, 8'h00, 1, 0, 4'h0);

    // constrained random: bursts of protection, random stalls
    for (int i = 0; i < 3000; i++) begin
      logic p;
      p = (($urandom % 8) < 3);
      step($urandom % 2, $urandom % 2, 8'($urandom), ($urandom % 4) != 0, p,
           4'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule